// File: doc/BRIEF.md
# Oscillator Source Switch Sequencer

This block is the control state machine that moves the system clock select between three oscillator sources: a raw (untrimmed) RC oscillator, a trimmed RC oscillator and a crystal oscillator. A switch is started by a one-cycle request carrying a target source code. The block then issues a fixed, glitch-safe series of register writes on a single write port, one write per cycle. These writes cover the oscillator ready and power controls, the trim register and its hold latch, the select register and its hold latch, and the crystal calibration engine enable. The clock multiplexer and the registers themselves sit outside the block.

For the trimmed RC, the trim code is chosen from an always-on saved code, then a fuse code, and the RC calibration engine is started when neither is valid. The crystal path works differently. It reuses a saved trim, or else writes the fuse trim, and runs the crystal calibration engine unless that engine already reports completion. It checks the engine's result against the maximum trim and stores the final code with its enable bit. A move from the raw RC to the crystal always passes through a complete switch to the trimmed RC first.

Top module: `osc_switch_seq`

## Requirements
- R1: A request is taken only in the idle state and only with target code 0 (raw RC), 1 (trimmed RC) or 2 (crystal). A request while a switch is running, or with code 3, causes no write and no completion pulse.
- R2: When cur_sel_i already equals the target, the only write is select-hold set (op 8, osc 0, data 1), followed by completion.
- R3: A move from raw RC to crystal first performs the full trimmed-RC switch, ending with its select write of data 1, before any write with osc 1 appears.
- R4: Each oscillator path writes ready high (op 1, data 1) and then power-up (op 2, data 1) before any trim write, and writes ready low (op 1, data 0) after its trim writes. The RC uses osc 0 and the crystal uses osc 1.
- R5: The RC trim code comes from the saved code when its enable is set, else from the fuse code when its enable is set. If neither enable is set, no RC trim write is made.
- R6: Every trim write is the three-write run trim-hold clear (op 3, data 1), trim (op 4, data = enable in bit DW-1 above the code zero-extended), trim-hold set (op 5, data 1).
- R7: Every select change is the three-write run select-hold clear (op 6), select (op 7, data = source code), select-hold set (op 8), all with osc 0.
- R8: When the trimmed RC was switched in without a trim write, one cal_start_o pulse follows the select-hold set, and completion waits for cal_done_i.
- R9: On the crystal path, a crystal fuse trim is written only when the saved crystal enable is clear and the fuse enable is set. If xfsm_done_i is high when checked, the engine is skipped. Otherwise op 9 (osc 1) writes 0 and then XFSM_KEY, and the block waits for xfsm_done_i.
- R10: err_o is set for the crystal result when the status is high and the final trim is at least the maximum, or when the status is low and the final trim differs from the maximum. Otherwise it is clear, and it is clear for non-crystal switches.
- R11: After the crystal check, the final crystal trim is written with its enable through the R6 run, then ready low, then the select run with data 2.
- R12: done_o is a single-cycle pulse in the cycle after the last write of a switch, carries no write, and err_o is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Switch request, one cycle |
| target_i | input | 2 | Target source code |
| cur_sel_i | input | 2 | Source currently selected |
| rct_saved_en_i | input | 1 | Saved RC trim valid |
| rct_saved_code_i | input | RC_W | Saved RC trim code |
| rct_fuse_en_i | input | 1 | Fuse RC trim valid |
| rct_fuse_code_i | input | RC_W | Fuse RC trim code |
| xtl_saved_en_i | input | 1 | Saved crystal trim valid |
| xtl_fuse_en_i | input | 1 | Fuse crystal trim valid |
| xtl_fuse_code_i | input | XT_W | Fuse crystal trim code |
| xfsm_done_i | input | 1 | Crystal calibration engine done |
| xfsm_status_i | input | 1 | Crystal calibration status bit |
| xfsm_trim_i | input | XT_W | Crystal engine final trim |
| xfsm_max_i | input | XT_W | Crystal engine maximum trim |
| cal_start_o | output | 1 | RC calibration start pulse |
| cal_done_i | input | 1 | RC calibration done |
| wr_valid_o | output | 1 | Register write this cycle |
| wr_op_o | output | 4 | Write kind code |
| wr_osc_o | output | 1 | Oscillator addressed: 0 RC, 1 crystal |
| wr_data_o | output | DW | Write data |
| done_o | output | 1 | Switch complete pulse |
| err_o | output | 1 | Crystal result inconsistent |

## Verification
The bench builds the block with an 8-bit RC trim, a 6-bit crystal trim and an engine key of 0x5A. The bench draws crystal final and maximum trims from the range 0 to 7, so equal, lower and higher results all occur often and both error rules fire in random runs. The short widths also keep the enable bit in the trim write easy to find at the top of the 9-bit data. Behavioural models of both calibration engines answer after a few cycles, which reaches the polling states, the engine-skip branch and the raw-to-crystal hop with and without RC calibration.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_READY      = 4'd1,
        OP_POWER      = 4'd2,
        OP_THOLD_CLR  = 4'd3,
        OP_TRIM       = 4'd4,
        OP_THOLD_SET  = 4'd5,
        OP_SHOLD_CLR  = 4'd6,
        OP_SEL        = 4'd7,
        OP_SHOLD_SET  = 4'd8,
        OP_XFSM_EN    = 4'd9
    } wr_op_e;

    localparam logic [1:0] SRC_RAW = 2'd0;
    localparam logic [1:0] SRC_RCT = 2'd1;
    localparam logic [1:0] SRC_XTL = 2'd2;

    typedef enum logic [4:0] {
        ST_IDLE, ST_FIN_HOLD,
        ST_R_RDY_OFF, ST_R_PWR, ST_R_THCLR, ST_R_TRIM, ST_R_THSET, ST_R_RDY_ON,
        ST_SCLR, ST_SEL, ST_SSET,
        ST_CAL_GO, ST_CAL_WAIT,
        ST_X_RDY_OFF, ST_X_PWR, ST_X_THCLR, ST_X_TRIM, ST_X_THSET,
        ST_X_FSMQ, ST_X_EN0, ST_X_KEY, ST_X_POLL,
        ST_X_WTHCLR, ST_X_WTRIM, ST_X_WTHSET, ST_X_RDY_ON
    } seq_state_e;

    // which trim location won the priority pick
    typedef enum logic [1:0] {
        PICK_NONE  = 2'd0,
        PICK_FUSE  = 2'd1,
        PICK_SAVED = 2'd2
    } pick_e;

endpackage

// File: rtl/osc_trim_pick.sv
module osc_trim_pick import osc_seq_pkg::*; #(
    parameter int W = 8
) (
    input  logic         sav_en_i,
    input  logic [W-1:0] sav_code_i,
    input  logic         fuse_en_i,
    input  logic [W-1:0] fuse_code_i,
    output logic [W-1:0] code_o,
    output pick_e        pick_o
);
    always_comb begin
        if (sav_en_i) begin
            code_o = sav_code_i;
            pick_o = PICK_SAVED;
        end else if (fuse_en_i) begin
            code_o = fuse_code_i;
            pick_o = PICK_FUSE;
        end else begin
            code_o = '0;
            pick_o = PICK_NONE;
        end
    end
endmodule

// File: rtl/osc_xtal_judge.sv
module osc_xtal_judge #(
    parameter int W = 6
) (
    input  logic         status_i,
    input  logic [W-1:0] trim_i,
    input  logic [W-1:0] max_i,
    output logic         err_o
);
    // status high: result must lie below the ceiling
    // status low: engine ran out, result must sit exactly on it
    always_comb begin
        if (status_i) err_o = (trim_i >= max_i);
        else          err_o = (trim_i != max_i);
    end
endmodule

// File: rtl/osc_switch_seq.sv
module osc_switch_seq import osc_seq_pkg::*; #(
    parameter  int RC_W     = 8,
    parameter  int XT_W     = 6,
    parameter  int XFSM_KEY = 'h5A,
    localparam int CW       = (RC_W > XT_W) ? RC_W : XT_W,
    localparam int DW       = CW + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_i,
    input  logic [1:0]      target_i,
    input  logic [1:0]      cur_sel_i,
    input  logic            rct_saved_en_i,
    input  logic [RC_W-1:0] rct_saved_code_i,
    input  logic            rct_fuse_en_i,
    input  logic [RC_W-1:0] rct_fuse_code_i,
    input  logic            xtl_saved_en_i,
    input  logic            xtl_fuse_en_i,
    input  logic [XT_W-1:0] xtl_fuse_code_i,
    input  logic            xfsm_done_i,
    input  logic            xfsm_status_i,
    input  logic [XT_W-1:0] xfsm_trim_i,
    input  logic [XT_W-1:0] xfsm_max_i,
    output logic            cal_start_o,
    input  logic            cal_done_i,
    output logic            wr_valid_o,
    output logic [3:0]      wr_op_o,
    output logic            wr_osc_o,
    output logic [DW-1:0]   wr_data_o,
    output logic            done_o,
    output logic            err_o
);

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       sel;      // source for the shared select run
        logic             hop;      // crystal path follows the RC path
        logic             rc_trim;  // RC path carries a trim write
        logic [CW-1:0]    code;     // code for the pending trim run
        logic             done;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;

    logic [RC_W-1:0] rc_code;
    pick_e           rc_pick;
    logic [XT_W-1:0] xt_code;
    pick_e           xt_pick;
    logic            xt_err;

    osc_trim_pick #(.W(RC_W)) i_rc_pick (
        .sav_en_i    (rct_saved_en_i),
        .sav_code_i  (rct_saved_code_i),
        .fuse_en_i   (rct_fuse_en_i),
        .fuse_code_i (rct_fuse_code_i),
        .code_o      (rc_code),
        .pick_o      (rc_pick)
    );

    // the saved crystal code lives in the always-on domain and is kept as is
    osc_trim_pick #(.W(XT_W)) i_xt_pick (
        .sav_en_i    (xtl_saved_en_i),
        .sav_code_i  ({XT_W{1'b0}}),
        .fuse_en_i   (xtl_fuse_en_i),
        .fuse_code_i (xtl_fuse_code_i),
        .code_o      (xt_code),
        .pick_o      (xt_pick)
    );

    osc_xtal_judge #(.W(XT_W)) i_judge (
        .status_i (xfsm_status_i),
        .trim_i   (xfsm_trim_i),
        .max_i    (xfsm_max_i),
        .err_o    (xt_err)
    );

    // next-state process
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_i && target_i != 2'd3) begin
                    s_d.err     = 1'b0;
                    s_d.hop     = 1'b0;
                    s_d.code    = CW'(rc_code);
                    s_d.rc_trim = (rc_pick != PICK_NONE);
                    if (cur_sel_i == target_i) begin
                        s_d.st = ST_FIN_HOLD;
                    end else if (target_i == SRC_RAW) begin
                        s_d.sel = SRC_RAW;
                        s_d.st  = ST_SCLR;
                    end else if (target_i == SRC_RCT) begin
                        s_d.st = ST_R_RDY_OFF;
                    end else if (cur_sel_i == SRC_RAW) begin
                        s_d.hop = 1'b1;
                        s_d.st  = ST_R_RDY_OFF;
                    end else begin
                        s_d.st = ST_X_RDY_OFF;
                    end
                end
            end
            ST_FIN_HOLD: begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
            ST_R_RDY_OFF: s_d.st = ST_R_PWR;
            ST_R_PWR:     s_d.st = s_q.rc_trim ? ST_R_THCLR : ST_R_RDY_ON;
            ST_R_THCLR:   s_d.st = ST_R_TRIM;
            ST_R_TRIM:    s_d.st = ST_R_THSET;
            ST_R_THSET:   s_d.st = ST_R_RDY_ON;
            ST_R_RDY_ON: begin
                s_d.sel = SRC_RCT;
                s_d.st  = ST_SCLR;
            end
            ST_SCLR: s_d.st = ST_SEL;
            ST_SEL:  s_d.st = ST_SSET;
            ST_SSET: begin
                if (s_q.sel == SRC_RCT && !s_q.rc_trim) begin
                    s_d.st = ST_CAL_GO;
                end else if (s_q.sel == SRC_RCT && s_q.hop) begin
                    s_d.st = ST_X_RDY_OFF;
                end else begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            ST_CAL_GO: s_d.st = ST_CAL_WAIT;
            ST_CAL_WAIT: begin
                if (cal_done_i) begin
                    if (s_q.hop) begin
                        s_d.st = ST_X_RDY_OFF;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            ST_X_RDY_OFF: s_d.st = ST_X_PWR;
            ST_X_PWR: begin
                if (xt_pick == PICK_FUSE) begin
                    s_d.code = CW'(xt_code);
                    s_d.st   = ST_X_THCLR;
                end else begin
                    s_d.st = ST_X_FSMQ;
                end
            end
            ST_X_THCLR: s_d.st = ST_X_TRIM;
            ST_X_TRIM:  s_d.st = ST_X_THSET;
            ST_X_THSET: s_d.st = ST_X_FSMQ;
            ST_X_FSMQ: begin
                if (xfsm_done_i) begin
                    s_d.code = CW'(xfsm_trim_i);
                    s_d.err  = xt_err;
                    s_d.st   = ST_X_WTHCLR;
                end else begin
                    s_d.st = ST_X_EN0;
                end
            end
            ST_X_EN0: s_d.st = ST_X_KEY;
            ST_X_KEY: s_d.st = ST_X_POLL;
            ST_X_POLL: begin
                if (xfsm_done_i) begin
                    s_d.code = CW'(xfsm_trim_i);
                    s_d.err  = xt_err;
                    s_d.st   = ST_X_WTHCLR;
                end
            end
            ST_X_WTHCLR: s_d.st = ST_X_WTRIM;
            ST_X_WTRIM:  s_d.st = ST_X_WTHSET;
            ST_X_WTHSET: s_d.st = ST_X_RDY_ON;
            ST_X_RDY_ON: begin
                s_d.sel = SRC_XTL;
                s_d.st  = ST_SCLR;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, sel: SRC_RAW, hop: 1'b0, rc_trim: 1'b0,
                     code: '0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // write port decode
    wr_op_e op;
    logic   osc;
    logic [DW-1:0] data;

    always_comb begin
        op   = OP_NONE;
        osc  = 1'b0;
        data = DW'(1);
        unique case (s_q.st)
            ST_R_RDY_OFF: op = OP_READY;
            ST_R_PWR:     op = OP_POWER;
            ST_R_THCLR:   op = OP_THOLD_CLR;
            ST_R_TRIM: begin
                op   = OP_TRIM;
                data = {1'b1, s_q.code};
            end
            ST_R_THSET:   op = OP_THOLD_SET;
            ST_R_RDY_ON: begin
                op   = OP_READY;
                data = '0;
            end
            ST_SCLR:      op = OP_SHOLD_CLR;
            ST_SEL: begin
                op   = OP_SEL;
                data = DW'(s_q.sel);
            end
            ST_SSET, ST_FIN_HOLD: op = OP_SHOLD_SET;
            ST_X_RDY_OFF: begin op = OP_READY; osc = 1'b1; end
            ST_X_PWR:     begin op = OP_POWER; osc = 1'b1; end
            ST_X_THCLR, ST_X_WTHCLR: begin op = OP_THOLD_CLR; osc = 1'b1; end
            ST_X_TRIM, ST_X_WTRIM: begin
                op   = OP_TRIM;
                osc  = 1'b1;
                data = {1'b1, s_q.code};
            end
            ST_X_THSET, ST_X_WTHSET: begin op = OP_THOLD_SET; osc = 1'b1; end
            ST_X_EN0: begin
                op   = OP_XFSM_EN;
                osc  = 1'b1;
                data = '0;
            end
            ST_X_KEY: begin
                op   = OP_XFSM_EN;
                osc  = 1'b1;
                data = DW'(XFSM_KEY);
            end
            ST_X_RDY_ON: begin
                op   = OP_READY;
                osc  = 1'b1;
                data = '0;
            end
            default: data = '0;
        endcase
    end

    assign wr_valid_o  = (op != OP_NONE);
    assign wr_op_o     = op;
    assign wr_osc_o    = osc;
    assign wr_data_o   = data;
    assign cal_start_o = (s_q.st == ST_CAL_GO);
    assign done_o      = s_q.done;
    assign err_o       = s_q.err;

endmodule

// File: rtl/osc_switch_seq_chk.sv
module osc_switch_seq_chk import osc_seq_pkg::*; (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_valid_o,
    input logic [3:0] wr_op_o,
    input logic       done_o,
    input logic       cal_start_o
);
    // R12: completion lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R12: completion cycle carries no write
    a_r12_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !wr_valid_o);

    // R7: select is preceded by hold clear and followed by hold set
    a_r7_sel_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_op_o == OP_SEL) |-> ($past(wr_op_o) == OP_SHOLD_CLR));
    a_r7_set_after_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_op_o == OP_SEL) |=> (wr_op_o == OP_SHOLD_SET));

    // R6: trim write is wrapped by the trim-hold run
    a_r6_trim_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_op_o == OP_TRIM) |-> ($past(wr_op_o) == OP_THOLD_CLR));
    a_r6_set_after_trim: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_op_o == OP_TRIM) |=> (wr_op_o == OP_THOLD_SET));

    // R8: calibration start follows the select-hold set and lasts one cycle
    a_r8_cal_after_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_start_o |-> ($past(wr_op_o) == OP_SHOLD_SET));
    a_r8_cal_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_start_o |=> !cal_start_o);
endmodule

bind osc_switch_seq osc_switch_seq_chk i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_o  (wr_valid_o),
    .wr_op_o     (wr_op_o),
    .done_o      (done_o),
    .cal_start_o (cal_start_o)
);

// File: tb/test_osc_switch_seq.sv
module test_osc_switch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RC_W = 8;
    localparam int XT_W = 6;
    localparam int KEY  = 'h5A;
    localparam int DW   = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            req = 1'b0;
    logic [1:0]      tgt = '0, cur = '0;
    logic            rse = 0, rfe = 0, xse = 0, xfe = 0;
    logic [RC_W-1:0] rsc = '0, rfc = '0;
    logic [XT_W-1:0] xfc = '0, xtr = '0, xmx = '0;
    logic            xst = 0, xd0 = 0, xload = 0;
    logic            xdone = 1'b0, cal_done = 1'b1;
    logic            cal_start, wr_valid, wr_osc, done, err;
    logic [3:0]      wr_op;
    logic [DW-1:0]   wr_data;

    osc_switch_seq #(.RC_W(RC_W), .XT_W(XT_W), .XFSM_KEY(KEY)) i_osc_switch_seq (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .target_i(tgt), .cur_sel_i(cur),
        .rct_saved_en_i(rse), .rct_saved_code_i(rsc),
        .rct_fuse_en_i(rfe), .rct_fuse_code_i(rfc),
        .xtl_saved_en_i(xse), .xtl_fuse_en_i(xfe), .xtl_fuse_code_i(xfc),
        .xfsm_done_i(xdone), .xfsm_status_i(xst), .xfsm_trim_i(xtr), .xfsm_max_i(xmx),
        .cal_start_o(cal_start), .cal_done_i(cal_done),
        .wr_valid_o(wr_valid), .wr_op_o(wr_op), .wr_osc_o(wr_osc), .wr_data_o(wr_data),
        .done_o(done), .err_o(err)
    );

    // crystal engine model: enable 0 clears done, key starts a short run
    int xcnt = 0;
    logic xrun = 1'b0;
    always @(posedge clk) begin
        if (xload) begin
            xdone <= xd0; xrun <= 1'b0;
        end else if (wr_valid && wr_op == 4'd9) begin
            if (wr_data == '0) begin xdone <= 1'b0; xrun <= 1'b0; end
            else begin xrun <= 1'b1; xcnt <= 0; end
        end else if (xrun) begin
            xcnt <= xcnt + 1;
            if (xcnt == 4) begin xdone <= 1'b1; xrun <= 1'b0; end
        end
    end

    // RC calibration engine model
    int ccnt = 0;
    always @(posedge clk) begin
        if (cal_start) begin cal_done <= 1'b0; ccnt <= 0; end
        else if (!cal_done) begin
            ccnt <= ccnt + 1;
            if (ccnt == 3) cal_done <= 1'b1;
        end
    end

    // monitor
    logic [13:0] log_q [64];
    int nlog = 0, ndone = 0, ncal = 0;
    logic err_at_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && nlog < 64) begin
                log_q[nlog] = {wr_op, wr_osc, wr_data};
                nlog = nlog + 1;
            end
            if (cal_start) ncal = ncal + 1;
            if (done) begin ndone = ndone + 1; err_at_done = err; end
        end
    end

    int checks = 0, fails = 0;
    task automatic check(input bit ok, input string req_tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, expv);
        end
    endtask

    // expected write list
    logic [13:0] exp_q [64];
    int nexp = 0;
    task automatic push(input int op, input bit osc, input int d);
        exp_q[nexp] = {4'(op), osc, 9'(d)};
        nexp++;
    endtask
    task automatic trim_run(input bit osc, input int code);
        push(3, osc, 1); push(4, osc, 256 | code); push(5, osc, 1);
    endtask
    task automatic sel_run(input int src);
        push(6, 0, 1); push(7, 0, src); push(8, 0, 1);
    endtask
    function automatic bit exp_err_f();
        if (tgt != 2 || cur == 2) return 1'b0;
        return xst ? (xtr >= xmx) : (xtr != xmx);
    endfunction
    int exp_cal;
    task automatic build_exp();
        nexp = 0; exp_cal = 0;
        if (cur == tgt) push(8, 0, 1);                      // R2
        else if (tgt == 0) sel_run(0);                       // R7
        else begin
            if (tgt == 1 || cur == 0) begin                  // R3 hop, R4
                push(1, 0, 1); push(2, 0, 1);
                if (rse) trim_run(0, int'(rsc));             // R5
                else if (rfe) trim_run(0, int'(rfc));
                else exp_cal = 1;                            // R8
                push(1, 0, 0);
                sel_run(1);
            end
            if (tgt == 2) begin
                push(1, 1, 1); push(2, 1, 1);
                if (!xse && xfe) trim_run(1, int'(xfc));     // R9
                if (!xd0) begin push(9, 1, 0); push(9, 1, KEY); end
                trim_run(1, int'(xtr));                      // R11
                push(1, 1, 0);
                sel_run(2);
            end
        end
    endtask

    task automatic run_case(input string tag, input bit poke);
        int seq_ok, t, first_bad;
        @(negedge clk);
        xload = 1'b1;
        @(negedge clk);
        xload = 1'b0;
        nlog = 0; ndone = 0; ncal = 0;
        build_exp();
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        t = 0;
        while (ndone == 0 && t < 400) begin
            if (poke && t == 2) begin
                req = 1'b1; tgt = (tgt == 0) ? 2'd1 : 2'd0;
            end else if (poke && t == 3) begin
                req = 1'b0; tgt = (tgt == 0) ? 2'd1 : 2'd0;
            end
            @(negedge clk); t++;
        end
        repeat (3) @(negedge clk);
        seq_ok = (nlog == nexp); first_bad = -1;
        for (int i = 0; i < nexp && i < nlog; i++)
            if (log_q[i] !== exp_q[i] && first_bad < 0) first_bad = i;
        if (first_bad >= 0) seq_ok = 0;
        check(seq_ok != 0, {tag, " write sequence"},
              first_bad >= 0 ? int'(log_q[first_bad]) : nlog,
              first_bad >= 0 ? int'(exp_q[first_bad]) : nexp);
        check(ndone == 1, {tag, " R12 one done pulse"}, ndone, 1);
        check(err_at_done == exp_err_f(), {tag, " R10 err at done"},
              int'(err_at_done), int'(exp_err_f()));
        check(ncal == exp_cal, {tag, " R8 cal starts"}, ncal, exp_cal);
    endtask

    task automatic set_case(input int c, input int g, input bit a, input bit b,
                            input bit xs, input bit xf, input bit d0, input bit st,
                            input int tr, input int mx);
        cur = 2'(c); tgt = 2'(g); rse = a; rfe = b; xse = xs; xfe = xf;
        xd0 = d0; xst = st; xtr = 6'(tr); xmx = 6'(mx);
        rsc = 8'h3C; rfc = 8'hC5; xfc = 6'h2B;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid && !done && !err && !cal_start, "reset R12 outputs idle",
              int'({wr_valid, done, err, cal_start}), 0);

        // directed corners
        set_case(1, 1, 1, 1, 0, 0, 0, 0, 0, 0); run_case("R2 same source", 0);
        set_case(2, 0, 0, 0, 0, 0, 0, 0, 0, 0); run_case("R7 to raw", 0);
        set_case(0, 1, 1, 1, 0, 0, 0, 0, 0, 0); run_case("R5 saved wins", 0);
        set_case(0, 1, 0, 1, 0, 0, 0, 0, 0, 0); run_case("R5 fuse used", 0);
        set_case(0, 1, 0, 0, 0, 0, 0, 0, 0, 0); run_case("R8 untrimmed RC", 0);
        set_case(0, 2, 0, 0, 0, 1, 0, 1, 3, 5); run_case("R3 hop with cal", 0);
        set_case(1, 2, 0, 0, 1, 1, 1, 1, 2, 5); run_case("R9 engine skipped", 0);
        set_case(1, 2, 0, 0, 0, 1, 0, 1, 5, 5); run_case("R10 status high at max", 0);
        set_case(1, 2, 0, 0, 0, 0, 0, 0, 5, 5); run_case("R10 status low at max", 0);
        set_case(1, 2, 0, 0, 0, 0, 0, 0, 3, 5); run_case("R10 status low below max", 0);
        set_case(1, 2, 0, 0, 0, 0, 0, 1, 1, 6); run_case("R11 writeback", 0);
        set_case(1, 2, 0, 0, 0, 1, 0, 1, 1, 6); run_case("R1 busy request ignored", 1);
        set_case(0, 1, 1, 0, 0, 0, 0, 0, 0, 0); run_case("R4 ready power order", 0);

        // R1: code 3 is ignored
        @(negedge clk);
        nlog = 0; ndone = 0;
        tgt = 2'd3; cur = 2'd1; req = 1'b1;
        @(negedge clk); req = 1'b0;
        repeat (10) @(negedge clk);
        check(nlog == 0 && ndone == 0, "R1 target code 3 ignored", nlog + ndone, 0);

        // random mix
        for (int k = 0; k < 40; k++) begin
            set_case($urandom % 3, $urandom % 3, 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     $urandom % 8, $urandom % 8);
            rsc = 8'($urandom); rfc = 8'($urandom); xfc = 6'($urandom);
            run_case("R6 random", 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule